// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block holds the execution mode of a processor core and steps it through the legal moves between real-address, protected, virtual-8086, long and system management modes. Each rising clock edge it looks at the control flags (protection enable, virtual-8086, paging), the long-mode enable bit of the extended feature register, the long bit of the current code segment, and two event pulses: a system-management interrupt request and a resume-from-system-management indication. It then updates the registered mode.

When the core enters system management mode, the block stores the mode it is leaving, including the long-mode sub-mode. On resume it returns to exactly that mode. It drives the mode as a code and as a one-hot vector. It also drives a long-mode-active bit, mirrored into a view of the extended feature register, and a sub-mode bit that tells 64-bit from compatibility operation. All pins are plain level control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `opmode_ctrl`

## Requirements
- R1: An active-low reset (asynchronous assert) forces real-address mode, long-mode-active 0 and sub-mode 0, from any mode including system management.
- R2: In real-address mode, `pe`=1 moves to protected mode at the next edge. In protected mode, `pe`=0 moves back to real-address mode.
- R3: In protected mode with `pe`=1, `vm`=1 moves to virtual-8086 mode. Virtual-8086 mode leaves only when `vm`=0, which returns it to protected mode. It ignores `pe`, `pg` and `lme`.
- R4: Long mode is entered only from protected mode, and only when `pe`=1, `vm`=0, `lme`=1 and `pg`=1 in the same cycle. `lme` without `pg` leaves the block in protected mode.
- R5: `lma` is 1 exactly while in long mode. In system management mode it holds the value it had when the interrupt was taken. `ext_feat` carries `lma` at bit 10, `lme` at bit 8, and zeros elsewhere.
- R6: In long mode, `sub_64` shows the `cs_l` value sampled at the previous edge: 1 for 64-bit, 0 for compatibility. `sub_64` is 0 in every other mode.
- R7: `smi_req` in real-address, protected, virtual-8086 or long mode enters system management mode at the next edge.
- R8: `rsm_done` in system management mode restores the saved mode, the saved sub-mode and the matching `lma`, whatever the flags are.
- R9: `smi_req` in system management mode is ignored. `rsm_done` outside system management mode has no effect.
- R10: In long mode, `pg`=0 or `lme`=0 returns to protected mode and clears `lma`.
- R11: Priority is reset, then `smi_req`, then `rsm_done` and flag-driven moves. `smi_req` together with a flag change or with `rsm_done` enters system management mode.
- R12: `mode` is encoded real=0, protected=1, virtual-8086=2, long=3, system management=4. `mode_oh` has exactly the bit at index `mode` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| pe | input | 1 | Protection-enable flag |
| vm | input | 1 | Virtual-8086 flag |
| pg | input | 1 | Paging-enable flag |
| lme | input | 1 | Long-mode enable from the extended feature register |
| cs_l | input | 1 | Long bit of the current code segment |
| smi_req | input | 1 | System-management interrupt request pulse |
| rsm_done | input | 1 | Resume-from-system-management pulse |
| mode | output | 3 | Current mode code |
| mode_oh | output | 5 | Current mode, one-hot |
| lma | output | 1 | Long-mode-active status |
| sub_64 | output | 1 | 1 = 64-bit sub-mode, 0 = compatibility |
| ext_feat | output | 16 | Extended feature register view (bit 8 enable, bit 10 active) |

## Verification
The assertions check the following on every cycle:
- entry into system management mode on a request;
- that a nested request is ignored;
- that resume returns to the mode recorded when the request was taken;
- agreement between `lma` and the long-mode code outside system management mode;
- the absence of any long-mode entry from real-address or virtual-8086 mode;
- the sub-mode following the segment long bit;
- the one-hot mirror.

Only the bench scenarios show the following:
- the ordering between simultaneous events, such as a request together with a resume or with a flag change;
- that resume ignores the flags present at that moment;
- that `lma` is held through system management mode;
- that reset recovers from inside system management mode.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 5;

  typedef enum logic [MODE_W-1:0] {
    M_REAL = 3'd0,
    M_PROT = 3'd1,
    M_V86  = 3'd2,
    M_LONG = 3'd3,
    M_SMM  = 3'd4
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  sub64;
  } ctx_t;
endpackage

// File: rtl/opmode_next.sv
module opmode_next
  import opmode_pkg::*;
(
  input  ctx_t cur,
  input  ctx_t saved,
  input  logic pe,
  input  logic vm,
  input  logic pg,
  input  logic lme,
  input  logic cs_l,
  input  logic smi_req,
  input  logic rsm_done,
  output ctx_t nxt,
  output logic take_smi,
  output logic take_rsm
);
  logic long_ok;
  assign long_ok  = lme && pg;
  assign take_smi = smi_req && (cur.mode != M_SMM);
  assign take_rsm = rsm_done && (cur.mode == M_SMM);

  always_comb begin
    nxt = cur;
    if (take_smi) begin
      nxt.mode = M_SMM;
    end else if (take_rsm) begin
      nxt = saved;
    end else begin
      unique case (cur.mode)
        M_REAL: begin
          nxt.sub64 = 1'b0;
          if (pe) nxt.mode = M_PROT;
        end
        M_PROT: begin
          nxt.sub64 = 1'b0;
          if (!pe)          nxt.mode = M_REAL;
          else if (vm)      nxt.mode = M_V86;
          else if (long_ok) begin
            nxt.mode  = M_LONG;
            nxt.sub64 = cs_l;
          end
        end
        M_V86: begin
          nxt.sub64 = 1'b0;
          if (!vm) nxt.mode = M_PROT;
        end
        M_LONG: begin
          if (!long_ok) begin
            nxt.mode  = M_PROT;
            nxt.sub64 = 1'b0;
          end else begin
            nxt.sub64 = cs_l;
          end
        end
        M_SMM: ;
        default: begin
          nxt.mode  = M_REAL;
          nxt.sub64 = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/opmode_save.sv
module opmode_save
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_smi,
  input  logic  take_rsm,
  input  ctx_t  cur,
  input  mode_e nxt_mode,
  output ctx_t  saved,
  output logic  lma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved <= '{mode: M_REAL, sub64: 1'b0};
    end else if (take_smi) begin
      saved <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lma <= 1'b0;
    end else if (take_rsm) begin
      lma <= (saved.mode == M_LONG);
    end else if (!(take_smi || cur.mode == M_SMM)) begin
      lma <= (nxt_mode == M_LONG);
    end
  end
endmodule

// File: rtl/opmode_status.sv
module opmode_status
  import opmode_pkg::*;
#(
  parameter int EXT_W   = 16,
  parameter int LME_POS = 8,
  parameter int LMA_POS = 10
) (
  input  ctx_t                 cur,
  input  logic                 lma,
  input  logic                 lme,
  output logic [NUM_MODES-1:0] mode_oh,
  output logic                 sub_64,
  output logic [EXT_W-1:0]     ext_feat
);
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_oh
    assign mode_oh[i] = (cur.mode == mode_e'(i));
  end

  for (genvar b = 0; b < EXT_W; b++) begin : g_ext
    if (b == LME_POS) begin : g_en
      assign ext_feat[b] = lme;
    end else if (b == LMA_POS) begin : g_act
      assign ext_feat[b] = lma;
    end else begin : g_zero
      assign ext_feat[b] = 1'b0;
    end
  end

  assign sub_64 = (cur.mode == M_LONG) && cur.sub64;
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int EXT_W   = 16,
  parameter int LME_POS = 8,
  parameter int LMA_POS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pe,
  input  logic                 vm,
  input  logic                 pg,
  input  logic                 lme,
  input  logic                 cs_l,
  input  logic                 smi_req,
  input  logic                 rsm_done,
  output logic [MODE_W-1:0]    mode,
  output logic [NUM_MODES-1:0] mode_oh,
  output logic                 lma,
  output logic                 sub_64,
  output logic [EXT_W-1:0]     ext_feat
);
  ctx_t cur, nxt, saved;
  logic take_smi, take_rsm;

  opmode_next u_next (
    .cur(cur), .saved(saved), .pe(pe), .vm(vm), .pg(pg), .lme(lme),
    .cs_l(cs_l), .smi_req(smi_req), .rsm_done(rsm_done),
    .nxt(nxt), .take_smi(take_smi), .take_rsm(take_rsm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '{mode: M_REAL, sub64: 1'b0};
    else        cur <= nxt;
  end

  opmode_save u_save (
    .clk(clk), .rst_n(rst_n), .take_smi(take_smi), .take_rsm(take_rsm),
    .cur(cur), .nxt_mode(nxt.mode), .saved(saved), .lma(lma)
  );

  opmode_status #(.EXT_W(EXT_W), .LME_POS(LME_POS), .LMA_POS(LMA_POS)) u_stat (
    .cur(cur), .lma(lma), .lme(lme),
    .mode_oh(mode_oh), .sub_64(sub_64), .ext_feat(ext_feat)
  );

  assign mode = cur.mode;
endmodule

// File: rtl/opmode_ctrl_sva.sv
module opmode_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       pe,
  input logic       vm,
  input logic       pg,
  input logic       lme,
  input logic       cs_l,
  input logic       smi_req,
  input logic       rsm_done,
  input logic [2:0] mode,
  input logic [4:0] mode_oh,
  input logic       lma,
  input logic       sub_64
);
  logic [2:0] shadow;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= 3'd0;
    else if (smi_req && mode != 3'd4) shadow <= mode;
  end

  p_reset_real_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 3'd0 && !lma && !sub_64));

  p_smi_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && mode != 3'd4) |=> (mode == 3'd4));

  p_smi_nested_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !rsm_done) |=> (mode == 3'd4));

  p_rsm_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && rsm_done) |=> (mode == $past(shadow)));

  p_lma_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd4) |-> (lma == (mode == 3'd3)));

  p_long_from_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd2) |=> (mode != 3'd3));

  p_long_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && pe && !vm && lme && pg && !smi_req) |=> (mode == 3'd3));

  p_sub_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && lme && pg && !smi_req) |=> (sub_64 == $past(cs_l)));

  p_long_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !(lme && pg) && !smi_req) |=> (mode == 3'd1 && !lma));

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mode_oh) && mode_oh[mode]);

  p_prot_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !pe && !smi_req) |=> (mode == 3'd0));

  p_v86_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !vm && !smi_req) |=> (mode == 3'd1));
endmodule

bind opmode_ctrl opmode_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .pe(pe), .vm(vm), .pg(pg), .lme(lme),
  .cs_l(cs_l), .smi_req(smi_req), .rsm_done(rsm_done),
  .mode(mode), .mode_oh(mode_oh), .lma(lma), .sub_64(sub_64)
);

// File: tb/opmode_ctrl_test.sv
module opmode_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic pe = 0, vm = 0, pg = 0, lme = 0, cs_l = 0, smi_req = 0, rsm_done = 0;
  logic [2:0]  mode;
  logic [4:0]  mode_oh;
  logic        lma, sub_64;
  logic [15:0] ext_feat;

  opmode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pe(pe), .vm(vm), .pg(pg), .lme(lme),
    .cs_l(cs_l), .smi_req(smi_req), .rsm_done(rsm_done),
    .mode(mode), .mode_oh(mode_oh), .lma(lma), .sub_64(sub_64), .ext_feat(ext_feat)
  );

  typedef struct {
    logic [2:0] m;
    logic       a;
    logic       s;
    logic       en;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per clock and compares after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.req, "mode", int'(mode), int'(e.m));
      chk("R12", "mode_oh", int'(mode_oh), 1 << e.m);
      chk(e.req, "lma", int'(lma), int'(e.a));
      chk(e.req, "sub_64", int'(sub_64), int'(e.s));
      chk("R5", "ext_feat[10]", int'(ext_feat[10]), int'(e.a));
      chk("R5", "ext_feat[8]", int'(ext_feat[8]), int'(e.en));
      chk("R5", "ext_feat other", int'(ext_feat & 16'hFAFF), 0);
    end
  end

  // driver: inputs (pe vm pg lme cs_l smi rsm), expected (mode lma sub)
  task automatic cyc(input logic i_pe, i_vm, i_pg, i_lme, i_csl, i_smi, i_rsm,
                     input logic [2:0] em, input logic ea, es, input string req);
    @(negedge clk);
    pe = i_pe; vm = i_vm; pg = i_pg; lme = i_lme; cs_l = i_csl;
    smi_req = i_smi; rsm_done = i_rsm;
    q.push_back('{m: em, a: ea, s: es, en: i_lme, req: req});
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    pe = 0; vm = 0; pg = 0; lme = 0; cs_l = 0; smi_req = 0; rsm_done = 0;
    q.push_back('{m: 3'd0, a: 1'b0, s: 1'b0, en: 1'b0, req: req});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset("R1");
    cyc(0,0,0,0,0,0,0, 3'd0,0,0, "R1");
    cyc(0,0,0,0,0,0,1, 3'd0,0,0, "R9");   // resume outside SMM ignored
    cyc(1,0,0,0,0,0,0, 3'd1,0,0, "R2");
    cyc(1,0,0,1,0,0,0, 3'd1,0,0, "R4");   // enable without paging
    cyc(1,1,0,0,0,0,0, 3'd2,0,0, "R3");
    cyc(1,1,1,1,1,0,0, 3'd2,0,0, "R4");   // no long entry from v86
    cyc(0,1,1,1,1,0,0, 3'd2,0,0, "R3");   // pe=0 ignored in v86
    cyc(1,0,1,1,1,0,0, 3'd1,0,0, "R3");
    cyc(1,0,1,1,1,0,0, 3'd3,1,1, "R4");
    cyc(1,0,1,1,0,0,0, 3'd3,1,0, "R6");
    cyc(1,0,1,1,1,0,0, 3'd3,1,1, "R6");
    cyc(1,0,1,1,1,1,0, 3'd4,1,0, "R7");   // lma held in SMM
    cyc(0,0,0,0,0,1,0, 3'd4,1,0, "R9");   // nested request ignored
    cyc(1,0,1,1,0,0,1, 3'd3,1,1, "R8");   // saved 64-bit sub-mode restored
    cyc(1,0,1,1,0,0,0, 3'd3,1,0, "R6");
    cyc(1,0,0,1,0,0,0, 3'd1,0,0, "R10");  // paging cleared
    cyc(1,0,1,1,1,0,0, 3'd3,1,1, "R4");
    cyc(1,0,1,0,1,0,0, 3'd1,0,0, "R10");  // enable cleared
    cyc(1,0,0,0,0,0,1, 3'd1,0,0, "R9");
    cyc(1,1,0,0,0,1,0, 3'd4,0,0, "R11");  // request beats vm
    cyc(1,1,0,0,0,0,1, 3'd1,0,0, "R8");   // resume ignores vm=1
    cyc(1,1,0,0,0,0,0, 3'd2,0,0, "R3");
    cyc(1,1,0,0,0,1,0, 3'd4,0,0, "R7");
    cyc(1,1,0,0,0,0,1, 3'd2,0,0, "R8");
    cyc(1,1,0,0,0,1,1, 3'd4,0,0, "R11");  // request beats resume outside SMM
    do_reset("R1");                        // reset out of SMM
    cyc(0,0,0,0,0,1,0, 3'd4,0,0, "R7");
    cyc(1,0,0,0,0,0,1, 3'd0,0,0, "R8");   // back to real despite pe=1
    cyc(1,0,0,0,0,0,0, 3'd1,0,0, "R2");
    cyc(0,0,0,0,0,0,0, 3'd0,0,0, "R2");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule